// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects five external interrupt pins: one non-maskable input and four maskable request pins numbered 5, 4, 1 and 0. Each pin is synchronized to the clock. Its edge or level is then detected and latched in a status flag. The flag is gated by a per-pin enable and by the CPU's two interrupt-mask bits. A fixed-priority arbiter picks one winner, and the winner's exception vector goes to the CPU on a valid/acknowledge handshake. A write-only register port sets the sense mode, the enables and the priority bits, and clears status flags. A wake output tells the power controller that a source allowed to end software standby is pending.

The CPU side is a three-state machine:
- **IDLE**: the machine looks for any eligible request. If one exists, the IDLE→PRESENT transition latches the winner's vector.
- **PRESENT**: `req_valid` is high and `req_vector` is frozen. `cpu_ack` causes the PRESENT→RETIRE transition. At that point a pending NMI is consumed.
- **RETIRE**: `req_valid` is low for exactly one cycle. The RETIRE→IDLE transition then allows a new arbitration.

Top module: `ext_irq_ctrl`

Pin order in `irq_pin`: bit 0 = IRQ0, bit 1 = IRQ1, bit 2 = IRQ4, bit 3 = IRQ5.

## Requirements
- R1: After reset, `req_valid` and `wake` are 0, all enables, sense bits, priority bits and the NMI polarity bit are 0, and no flag is set.
- R2: Every pin passes through two synchronizer flops before detection. A pin change applied before clock edge k can set a flag at edge k+2 at the earliest, and can raise `req_valid` at edge k+3 at the earliest.
- R3: Level mode is selected when sense bit i is 0 in register address 0. In this mode a synchronized low level sets flag i on every clock. A clear written while the pin is still low has no lasting effect. A clear written after the pin has returned high removes the flag.
- R4: Edge mode is selected when sense bit i is 1. In this mode a synchronized high-to-low transition sets flag i. The flag stays set after the pin returns high, until software writes a 1 to bit i of address 3. When a clear and a set happen in the same cycle, the set wins.
- R5: A flag takes part in arbitration only when its enable bit (address 1, bit i) is 1. While the enable is 0 the flag is still latched, so it requests as soon as the enable is set.
- R6: Bit 4 of address 0 selects the NMI trigger edge: 0 = falling, 1 = rising. The other edge is ignored. The NMI vector is 7.
- R7: A pending NMI is presented regardless of `cpu_mask` and enables, and it wins over every IRQ.
- R8: `cpu_mask[0]` is the main mask and `cpu_mask[1]` is the auxiliary mask. An IRQ at priority level 0 is blocked when `cpu_mask[0]`=1. An IRQ at level 1 is blocked only when both mask bits are 1.
- R9: Address 2 holds the priority bits: bit 0 for IRQ0, bit 1 for IRQ1, bit 2 shared by IRQ4 and IRQ5. An eligible level-1 request beats any level-0 request. Between equal levels the lower pin index wins. The vectors are IRQ0=12, IRQ1=13, IRQ4=16, IRQ5=17.
- R10: `req_valid` stays high with `req_vector` unchanged until `cpu_ack` is sampled high. It is then low for exactly one cycle before the next request can appear.
- R11: An acknowledge consumes a pending NMI. An acknowledge does not clear an IRQ flag, so an uncleared IRQ is presented again.
- R12: `wake` is 1 when an NMI is pending, or when IRQ0 or IRQ1 has its flag and its enable both set. IRQ4 and IRQ5 never drive `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| irq_pin | input | 4 | Maskable pins {IRQ5, IRQ4, IRQ1, IRQ0}, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 sense/NMI polarity, 1 enable, 2 priority, 3 flag clear |
| reg_wdata | input | 8 | Register write data |
| cpu_mask | input | 2 | CPU mask bits: bit 0 main, bit 1 auxiliary |
| cpu_ack | input | 1 | CPU accepts the presented request |
| req_valid | output | 1 | A request is presented |
| req_vector | output | 8 | Exception vector of the presented request |
| wake | output | 1 | A standby-wake source is pending |

## Verification
A flag stuck at 1 shows up as a request, or as a `wake`, no more than one cycle after it could first be eligible. A flag that never sets shows up as a missing `req_valid` three cycles after the pin edge. A wrong arbitration state shows in the vector latched at the IDLE→PRESENT transition. The latched vector is stable, so the error stays visible until the acknowledge. A lost or stuck NMI pending bit shows in two ways: the vector-7 presentation is missing, or it appears again right after the one-cycle RETIRE gap. A reference model compared on every clock catches each of these in the cycle where it first appears.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int NUM_IRQ  = 4;
    localparam int VEC_W    = 8;
    localparam int PRIO_W   = 3;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;
    localparam int NMI_POL_BIT = 4;

    localparam logic [ADDR_W-1:0] ADR_SENSE = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_EN    = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_PRIO  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_CLR   = 2'd3;

    localparam logic [VEC_W-1:0] VEC_NMI = 8'd7;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESENT = 2'd1,
        ST_RETIRE  = 2'd2
    } arb_state_e;

    // Vector assigned to pin index (0:IRQ0 1:IRQ1 2:IRQ4 3:IRQ5)
    function automatic logic [VEC_W-1:0] irq_vector(input int idx);
        case (idx)
            0:       return 8'd12;
            1:       return 8'd13;
            2:       return 8'd16;
            default: return 8'd17;
        endcase
    endfunction

    // Which priority bit governs a pin index
    function automatic int prio_bit_of(input int idx);
        return (idx < 2) ? idx : 2;
    endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise,
    output logic [N-1:0] low
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    for (genvar g = 0; g < N; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b1;
                sync_q[g] <= 1'b1;
                prev_q[g] <= 1'b1;
            end else begin
                meta_q[g] <= pin[g];
                sync_q[g] <= meta_q[g];
                prev_q[g] <= sync_q[g];
            end
        end
        assign fall[g] = prev_q[g] & ~sync_q[g];
        assign rise[g] = ~prev_q[g] & sync_q[g];
        assign low[g]  = ~sync_q[g];
    end
endmodule

// File: rtl/eirq_flags.sv
module eirq_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sense_edge,
    input  logic [N-1:0] fall,
    input  logic [N-1:0] low,
    input  logic [N-1:0] clr,
    input  logic         nmi_edge,
    input  logic         nmi_clr,
    output logic [N-1:0] flag,
    output logic         nmi_pend
);
    logic [N-1:0] set_v;

    for (genvar g = 0; g < N; g++) begin : g_flag
        assign set_v[g] = sense_edge[g] ? fall[g] : low[g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag[g] <= 1'b0;
            else
                flag[g] <= set_v[g] | (flag[g] & ~clr[g]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            nmi_pend <= 1'b0;
        else
            nmi_pend <= nmi_edge | (nmi_pend & ~nmi_clr);
    end
endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter
    import eirq_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]      flag,
    input  logic [N-1:0]      enable,
    input  logic [PRIO_W-1:0] prio,
    input  logic [1:0]        cpu_mask,
    input  logic              nmi_pend,
    output logic              any_req,
    output logic [VEC_W-1:0]  win_vec,
    output logic              win_nmi
);
    logic [N-1:0] lvl, elig, hi, pool;

    for (genvar g = 0; g < N; g++) begin : g_lvl
        assign lvl[g]  = prio[prio_bit_of(g)];
        assign elig[g] = flag[g] & enable[g] &
                         (lvl[g] ? ~(cpu_mask[0] & cpu_mask[1]) : ~cpu_mask[0]);
    end

    assign hi   = elig & lvl;
    assign pool = (|hi) ? hi : elig;

    always_comb begin
        win_vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pool[i]) win_vec = irq_vector(i);
        end
        win_nmi = nmi_pend;
        if (nmi_pend) win_vec = VEC_NMI;
        any_req = nmi_pend | (|elig);
    end
endmodule

// File: rtl/eirq_fsm.sv
module eirq_fsm
    import eirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_req,
    input  logic [VEC_W-1:0] win_vec,
    input  logic             win_nmi,
    input  logic             cpu_ack,
    output logic             req_valid,
    output logic [VEC_W-1:0] req_vector,
    output logic             nmi_clr,
    output logic             is_idle
);
    arb_state_e state_q, state_d;
    logic       latch_win;
    logic       held_nmi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        latch_win = 1'b0;
        nmi_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) begin
                    state_d   = ST_PRESENT;
                    latch_win = 1'b1;
                end
            end
            ST_PRESENT: begin
                if (cpu_ack) begin
                    state_d = ST_RETIRE;
                    nmi_clr = held_nmi_q;
                end
            end
            ST_RETIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_vector <= '0;
            held_nmi_q <= 1'b0;
        end else if (latch_win) begin
            req_vector <= win_vec;
            held_nmi_q <= win_nmi;
        end
    end

    assign req_valid = (state_q == ST_PRESENT);
    assign is_idle   = (state_q == ST_IDLE);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter logic [NUM_IRQ-1:0] WAKE_MASK = 4'b0011
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nmi_pin,
    input  logic [NUM_IRQ-1:0]  irq_pin,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [1:0]          cpu_mask,
    input  logic                cpu_ack,
    output logic                req_valid,
    output logic [VEC_W-1:0]    req_vector,
    output logic                wake
);
    localparam int NPIN = NUM_IRQ + 1;
    localparam int NMI_IDX = NUM_IRQ;

    logic [NUM_IRQ-1:0] sense_q, en_q, irq_flag, clr_v;
    logic [PRIO_W-1:0]  prio_q;
    logic               nmi_rise_q;
    logic [NPIN-1:0]    fall_v, rise_v, low_v;
    logic               nmi_edge, nmi_pend, nmi_clr, fsm_idle;
    logic               any_req, win_nmi;
    logic [VEC_W-1:0]   win_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q    <= '0;
            nmi_rise_q <= 1'b0;
            en_q       <= '0;
            prio_q     <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                ADR_SENSE: begin
                    sense_q    <= reg_wdata[NUM_IRQ-1:0];
                    nmi_rise_q <= reg_wdata[NMI_POL_BIT];
                end
                ADR_EN:   en_q   <= reg_wdata[NUM_IRQ-1:0];
                ADR_PRIO: prio_q <= reg_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    assign clr_v = {NUM_IRQ{reg_we && (reg_addr == ADR_CLR)}} & reg_wdata[NUM_IRQ-1:0];

    eirq_sync #(.N(NPIN)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({nmi_pin, irq_pin}),
        .fall (fall_v),
        .rise (rise_v),
        .low  (low_v)
    );

    assign nmi_edge = nmi_rise_q ? rise_v[NMI_IDX] : fall_v[NMI_IDX];

    eirq_flags #(.N(NUM_IRQ)) flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sense_edge(sense_q),
        .fall      (fall_v[NUM_IRQ-1:0]),
        .low       (low_v[NUM_IRQ-1:0]),
        .clr       (clr_v),
        .nmi_edge  (nmi_edge),
        .nmi_clr   (nmi_clr),
        .flag      (irq_flag),
        .nmi_pend  (nmi_pend)
    );

    eirq_arbiter #(.N(NUM_IRQ)) arb_i (
        .flag    (irq_flag),
        .enable  (en_q),
        .prio    (prio_q),
        .cpu_mask(cpu_mask),
        .nmi_pend(nmi_pend),
        .any_req (any_req),
        .win_vec (win_vec),
        .win_nmi (win_nmi)
    );

    eirq_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req   (any_req),
        .win_vec   (win_vec),
        .win_nmi   (win_nmi),
        .cpu_ack   (cpu_ack),
        .req_valid (req_valid),
        .req_vector(req_vector),
        .nmi_clr   (nmi_clr),
        .is_idle   (fsm_idle)
    );

    assign wake = nmi_pend | (|(irq_flag & en_q & WAKE_MASK));
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
    import eirq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VEC_W-1:0]   req_vector,
    input logic               cpu_ack,
    input logic               wake,
    input logic               nmi_pend,
    input logic               fsm_idle,
    input logic [NUM_IRQ-1:0] flags,
    input logic [NUM_IRQ-1:0] enables,
    input logic [NUM_IRQ-1:0] sense,
    input logic [NUM_IRQ:0]   low
);
    assert_hold_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cpu_ack) |=> (req_valid && $stable(req_vector)));

    assert_retire_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cpu_ack) |=> !req_valid);

    assert_nmi_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && fsm_idle) |=> (req_valid && req_vector == VEC_NMI));

    assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && req_vector != VEC_NMI) |-> $past(|(flags & enables)));

    assert_wake_nmi_R12: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |-> wake);

    assert_wake_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_pend && !(|(flags[1:0] & enables[1:0]))) |-> !wake);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_lvl
        assert_level_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!sense[g] && low[g]) |=> flags[g]);
    end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vector(req_vector),
    .cpu_ack   (cpu_ack),
    .wake      (wake),
    .nmi_pend  (nmi_pend),
    .fsm_idle  (fsm_idle),
    .flags     (irq_flag),
    .enables   (en_q),
    .sense     (sense_q),
    .low       (low_v)
);

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b1;
    logic [3:0] irq_pin = 4'hF;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [1:0] cpu_mask = 2'd0;
    logic       cpu_ack = 1'b0;
    logic       req_valid, wake;
    logic [7:0] req_vector;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cpu_mask(cpu_mask), .cpu_ack(cpu_ack),
        .req_valid(req_valid), .req_vector(req_vector), .wake(wake)
    );

    // ---------------- behavioural reference model ----------------
    logic [4:0] m_s1, m_s2, m_d;
    logic [3:0] m_flag, m_sense, m_en;
    logic [2:0] m_prio;
    logic       m_nrise, m_npend, m_wn;
    int         m_state;
    logic [7:0] m_vec;

    function automatic logic [7:0] vec_of(input int i);
        int t[4] = '{12, 13, 16, 17};
        return 8'(t[i]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '1; m_s2 = '1; m_d = '1;
            m_flag = 0; m_sense = 0; m_en = 0; m_prio = 0;
            m_nrise = 0; m_npend = 0; m_wn = 0; m_state = 0; m_vec = 0;
        end else begin
            logic [4:0] fe, re;
            logic nedge, nclr, any, wn;
            int best, bestlvl;
            logic [7:0] v;
            fe = m_d & ~m_s2;
            re = ~m_d & m_s2;
            nedge = m_nrise ? re[4] : fe[4];
            best = -1; bestlvl = -1;
            for (int i = 0; i < 4; i++) begin
                int lv;
                bit blocked;
                lv = (i < 2) ? int'(m_prio[i]) : int'(m_prio[2]);
                blocked = (lv == 1) ? (cpu_mask == 2'b11) : cpu_mask[0];
                if (m_flag[i] && m_en[i] && !blocked && lv > bestlvl) begin
                    best = i; bestlvl = lv;
                end
            end
            any = m_npend || (best >= 0);
            wn = m_npend;
            v = m_npend ? 8'd7 : (best >= 0 ? vec_of(best) : 8'd0);
            nclr = 0;
            case (m_state)
                0: if (any) begin m_state = 1; m_vec = v; m_wn = wn; end
                1: if (cpu_ack) begin m_state = 2; nclr = m_wn; end
                default: m_state = 0;
            endcase
            for (int i = 0; i < 4; i++) begin
                bit st, cl;
                st = m_sense[i] ? fe[i] : !m_s2[i];
                cl = reg_we && reg_addr == 2'd3 && reg_wdata[i];
                m_flag[i] = st || (m_flag[i] && !cl);
            end
            m_npend = nedge || (m_npend && !nclr);
            if (reg_we) begin
                case (reg_addr)
                    2'd0: begin m_sense = reg_wdata[3:0]; m_nrise = reg_wdata[4]; end
                    2'd1: m_en = reg_wdata[3:0];
                    2'd2: m_prio = reg_wdata[2:0];
                    default: ;
                endcase
            end
            m_d = m_s2; m_s2 = m_s1; m_s1 = {nmi_pin, irq_pin};
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic mv, mw;
            mv = (m_state == 1);
            mw = m_npend || (m_flag[0] && m_en[0]) || (m_flag[1] && m_en[1]);
            checks += 3;
            if (req_valid !== mv) begin
                errors++; $display("FAIL R10 model req_valid act=%0b exp=%0b t=%0t", req_valid, mv, $time);
            end
            if (mv && req_vector !== m_vec) begin
                errors++; $display("FAIL R9 model req_vector act=%0d exp=%0d t=%0t", req_vector, m_vec, $time);
            end
            if (wake !== mw) begin
                errors++; $display("FAIL R12 model wake act=%0b exp=%0b t=%0t", wake, mw, $time);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_we = 0;
    endtask

    task automatic pulse(input logic [3:0] pins);
        @(negedge clk); #1;
        irq_pin = irq_pin & ~pins;
        idle(3);
        irq_pin = irq_pin | pins;
    endtask

    task automatic do_ack(input logic [3:0] clr);
        @(negedge clk); #1;
        cpu_ack = 1;
        if (clr != 0) begin reg_we = 1; reg_addr = 2'd3; reg_wdata = {4'h0, clr}; end
        @(negedge clk); #1;
        cpu_ack = 0; reg_we = 0;
    endtask

    task automatic wait_req(input int maxc, output bit seen);
        seen = 0;
        for (int i = 0; i < maxc && !seen; i++) begin
            @(negedge clk);
            if (req_valid) seen = 1;
        end
        #1;
    endtask

    initial begin
        bit s;
        idle(3);
        rst_n = 1;
        idle(1);
        chk("R1 req_valid after reset", req_valid, 0);
        chk("R1 wake after reset", wake, 0);
        pulse(4'b0001);
        idle(6);
        chk("R1 enables reset to zero", req_valid, 0);
        wr(2'd3, 8'h0F);
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h0F);

        // R2/R4 edge sensing on IRQ4
        pulse(4'b0100);
        wait_req(10, s);
        chk("R2 request seen", s, 1);
        chk("R2 vector IRQ4", req_vector, 16);
        idle(5);
        chk("R4 flag held after pin high", req_valid, 1);
        do_ack(4'b0100);
        idle(4);
        chk("R10 no request after ack+clear", req_valid, 0);

        // R11 ack does not clear an IRQ flag
        pulse(4'b1000);
        wait_req(10, s);
        do_ack(4'b0000);
        chk("R10 retire gap", req_valid, 0);
        wait_req(4, s);
        chk("R11 uncleared IRQ5 re-presented", s, 1);
        chk("R11 vector IRQ5", req_vector, 17);
        do_ack(4'b1000);
        idle(4);

        // R9 equal priority, lower index wins
        pulse(4'b1100);
        wait_req(10, s);
        chk("R9 equal level lower index", req_vector, 16);
        do_ack(4'b0100);
        wait_req(6, s);
        chk("R9 next winner IRQ5", req_vector, 17);
        do_ack(4'b1000);

        // R9 priority level dominates index
        wr(2'd2, 8'h04);
        pulse(4'b0101);
        wait_req(10, s);
        chk("R9 level1 IRQ4 beats IRQ0", req_vector, 16);
        do_ack(4'b0100);
        wait_req(6, s);
        chk("R9 then IRQ0", req_vector, 12);
        do_ack(4'b0001);
        wr(2'd2, 8'h00);

        // R5 enable gating
        wr(2'd1, 8'h0D);
        pulse(4'b0010);
        idle(8);
        chk("R5 disabled IRQ1 silent", req_valid, 0);
        wr(2'd1, 8'h0F);
        wait_req(4, s);
        chk("R5 latched flag requests on enable", s, 1);
        chk("R5 vector IRQ1", req_vector, 13);
        do_ack(4'b0010);
        idle(4);

        // R3 level sensing on IRQ0
        wr(2'd0, 8'h0E);
        irq_pin[0] = 0;
        wait_req(10, s);
        chk("R3 level request", req_vector, 12);
        do_ack(4'b0001);
        wait_req(6, s);
        chk("R3 clear while low has no lasting effect", s, 1);
        irq_pin[0] = 1;
        idle(4);
        do_ack(4'b0001);
        idle(5);
        chk("R3 clear after release sticks", req_valid, 0);
        wr(2'd0, 8'h0F);

        // R8 masking
        cpu_mask = 2'b01;
        pulse(4'b0001);
        idle(8);
        chk("R8 level0 blocked by main mask", req_valid, 0);
        wr(2'd2, 8'h01);
        wait_req(4, s);
        chk("R8 level1 passes main mask only", s, 1);
        do_ack(4'b0001);
        cpu_mask = 2'b11;
        pulse(4'b0001);
        idle(8);
        chk("R8 level1 blocked by both masks", req_valid, 0);
        cpu_mask = 2'b00;
        wait_req(4, s);
        chk("R8 released after unmask", s, 1);
        do_ack(4'b0001);
        wr(2'd2, 8'h00);

        // R12 wake sources
        cpu_mask = 2'b11;
        pulse(4'b0100);
        idle(6);
        chk("R12 IRQ4 does not wake", wake, 0);
        pulse(4'b0001);
        idle(6);
        chk("R12 IRQ0 wakes", wake, 1);
        wr(2'd3, 8'h0F);
        idle(2);
        chk("R12 wake drops after clear", wake, 0);

        // R7/R6 NMI under full mask, falling edge
        nmi_pin = 0;
        wait_req(10, s);
        chk("R7 NMI ignores masks", s, 1);
        chk("R6 NMI vector", req_vector, 7);
        chk("R12 NMI wakes", wake, 1);
        do_ack(4'b0000);
        idle(4);
        chk("R11 NMI consumed by ack", req_valid, 0);
        nmi_pin = 1;
        idle(6);
        chk("R6 rising ignored in falling mode", req_valid, 0);
        wr(2'd0, 8'h1F);
        nmi_pin = 0;
        idle(6);
        chk("R6 falling ignored in rising mode", req_valid, 0);
        nmi_pin = 1;
        wait_req(10, s);
        chk("R6 rising edge triggers", req_vector, 7);
        do_ack(4'b0000);
        cpu_mask = 2'b00;
        nmi_pin = 0;
        idle(6);

        // R7 NMI beats a simultaneous IRQ
        irq_pin[3] = 0; nmi_pin = 1;
        wait_req(10, s);
        chk("R7 NMI wins over IRQ5", req_vector, 7);
        do_ack(4'b0000);
        wait_req(6, s);
        chk("R7 IRQ5 follows", req_vector, 17);
        irq_pin[3] = 1;
        do_ack(4'b1000);
        idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule